// File: doc/BRIEF.md
# Block Memory Transfer Engine

This block is the sequencer behind an 8-bit processor's block-copy instructions. A single-cycle start pulse hands it a 2-bit mode together with the current source pointer (HL), destination pointer (DE) and byte counter (BC). For each element it reads one byte at the source address and then writes that byte to the destination address. After the write it steps both pointers by one in the selected direction and decrements the counter.

In single mode it moves exactly one element. In repeat mode it keeps moving elements until the counter reaches zero. When it finishes it presents the updated pointer and counter values and the flag updates for H, N and P/V, and it pulses done. Memory is reached through two valid/ready channels, one for reads and one for writes. Every request waits for its ready, so the memory sets the pace of each element.

Top module: `blkx_engine`

## Requirements
- R1: `mode_i` bit 0 selects the direction (0 = increment, 1 = decrement) and bit 1 selects repeat (1) or single (0). The instruction second bytes 0xA0, 0xA8, 0xB0 and 0xB8 map to 00, 01, 10 and 11. A start seen while idle captures `hl_i`, `de_i`, `bc_i` and the mode.
- R2: Each element is one read at the current HL address followed by one write of exactly that byte to the current DE address. A request holds its address until its ready is seen, and reads and writes are never requested in the same cycle.
- R3: After each element, HL and DE both step by one in the selected direction, wrapping modulo 2^16. BC decrements by one, and 0x0000 becomes 0xFFFF.
- R4: Single mode moves exactly one element, whatever the value of BC.
- R5: Repeat mode moves elements until BC becomes zero and ends with BC = 0. A start with BC = 0 moves 65536 elements.
- R6: At finish, H = 0 and N = 0, and P/V = 1 exactly when the final BC is non-zero. A repeat transfer therefore always ends with P/V = 0.
- R7: `busy_o` is high from the cycle after an accepted start through the done cycle. `done_o` is high for exactly one cycle per transfer, and the result outputs are valid in that cycle.
- R8: A start pulse while busy is ignored and does not change the running transfer or its result.
- R9: After reset the engine is idle: no busy, no done, no read or write request, and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_i | input | 2 | {repeat, decrement} |
| hl_i | input | 16 | Initial source pointer |
| de_i | input | 16 | Initial destination pointer |
| bc_i | input | 16 | Initial element count |
| rd_valid_o | output | 1 | Read request |
| rd_addr_o | output | 16 | Read address |
| rd_ready_i | input | 1 | Read accepted; data valid in the same cycle |
| rd_data_i | input | 8 | Read data |
| wr_valid_o | output | 1 | Write request |
| wr_addr_o | output | 16 | Write address |
| wr_data_o | output | 8 | Write data |
| wr_ready_i | input | 1 | Write accepted |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hl_o | output | 16 | Current/final source pointer |
| de_o | output | 16 | Current/final destination pointer |
| bc_o | output | 16 | Current/final counter |
| flag_h_o | output | 1 | H flag update (cleared) |
| flag_n_o | output | 1 | N flag update (cleared) |
| flag_pv_o | output | 1 | P/V flag update |

## Verification
A wrong pointer step or a wrong byte latch shows on the very next write request as a bad address or bad data. The bench compares every write against an address and data sequence it computes on its own. A wrong counter or a wrong stop decision shows at done as an element count that is off by one or more, a non-zero final BC in repeat mode, or a wrong P/V. The transfer with an initial count of zero makes a bad wrap test either end after one element or never end. Stalled ready patterns expose a request that changes its address before it is accepted.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } blkx_state_e;

  typedef struct packed {
    logic rpt;
    logic dec;
  } blkx_mode_t;
endpackage

// File: rtl/blkx_step.sv
module blkx_step #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (dec_i) val_o = val_i - ONE;
    else       val_o = val_i + ONE;
  end
endmodule

// File: rtl/blkx_fsm.sv
module blkx_fsm
  import blkx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rpt_i,
  input  logic        last_i,
  input  logic        rd_ready_i,
  input  logic        wr_ready_i,
  output logic        load_o,
  output logic        rd_fire_o,
  output logic        wr_fire_o,
  output logic        rd_valid_o,
  output logic        wr_valid_o,
  output logic        busy_o,
  output logic        done_o
);
  blkx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)    state_d = ST_RD;
      ST_RD:   if (rd_ready_i) state_d = ST_WR;
      ST_WR: begin
        if (wr_ready_i) begin
          if (rpt_i && !last_i) state_d = ST_RD;
          else                  state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign rd_valid_o = (state_q == ST_RD);
  assign wr_valid_o = (state_q == ST_WR);
  assign load_o     = (state_q == ST_IDLE) && start_i;
  assign rd_fire_o  = rd_valid_o && rd_ready_i;
  assign wr_fire_o  = wr_valid_o && wr_ready_i;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R7
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid_o && wr_valid_o)) else $error("read and write together"); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rd_valid_o && !wr_valid_o && !done_o)) else $error("request while idle"); // R9
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire_o |=> wr_valid_o) else $error("read not followed by write"); // R2
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o) else $error("busy dropped before done"); // R8
endmodule

// File: rtl/blkx_engine.sv
module blkx_engine
  import blkx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic [ADDR_W-1:0] de_i,
  input  logic [ADDR_W-1:0] bc_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ready_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] hl_o,
  output logic [ADDR_W-1:0] de_o,
  output logic [ADDR_W-1:0] bc_o,
  output logic              flag_h_o,
  output logic              flag_n_o,
  output logic              flag_pv_o
);
  blkx_mode_t        mode_q, mode_d;
  logic [ADDR_W-1:0] hl_q, hl_d, de_q, de_d, bc_q, bc_d;
  logic [ADDR_W-1:0] hl_nx, de_nx, bc_nx;
  logic [DATA_W-1:0] data_q, data_d;
  logic              pv_q, pv_d;
  logic              load, rd_fire, wr_fire, last;

  assign last = (bc_nx == '0);

  blkx_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rpt_i      (mode_q.rpt),
    .last_i     (last),
    .rd_ready_i (rd_ready_i),
    .wr_ready_i (wr_ready_i),
    .load_o     (load),
    .rd_fire_o  (rd_fire),
    .wr_fire_o  (wr_fire),
    .rd_valid_o (rd_valid_o),
    .wr_valid_o (wr_valid_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  blkx_step #(.W(ADDR_W)) u_hl_step (.val_i(hl_q), .dec_i(mode_q.dec), .val_o(hl_nx));
  blkx_step #(.W(ADDR_W)) u_de_step (.val_i(de_q), .dec_i(mode_q.dec), .val_o(de_nx));
  blkx_step #(.W(ADDR_W)) u_bc_step (.val_i(bc_q), .dec_i(1'b1),       .val_o(bc_nx));

  always_comb begin
    mode_d = mode_q;
    hl_d   = hl_q;
    de_d   = de_q;
    bc_d   = bc_q;
    data_d = data_q;
    pv_d   = pv_q;
    if (load) begin
      mode_d = blkx_mode_t'(mode_i);
      hl_d   = hl_i;
      de_d   = de_i;
      bc_d   = bc_i;
    end
    if (rd_fire) data_d = rd_data_i;
    if (wr_fire) begin
      hl_d = hl_nx;
      de_d = de_nx;
      bc_d = bc_nx;
      pv_d = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      hl_q   <= '0;
      de_q   <= '0;
      bc_q   <= '0;
      data_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      hl_q   <= hl_d;
      de_q   <= de_d;
      bc_q   <= bc_d;
      data_q <= data_d;
      pv_q   <= pv_d;
    end
  end

  assign rd_addr_o = hl_q;
  assign wr_addr_o = de_q;
  assign wr_data_o = data_q;
  assign hl_o      = hl_q;
  assign de_o      = de_q;
  assign bc_o      = bc_q;
  assign flag_h_o  = 1'b0;
  assign flag_n_o  = 1'b0;
  assign flag_pv_o = pv_q;

  AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o))) else $error("read addr moved"); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))) else $error("write moved"); // R2
  AST_BC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (bc_o == $past(bc_o) - 16'd1)) else $error("counter step wrong"); // R3
  AST_PV_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_pv_o == (bc_o != '0))) else $error("P/V mismatch"); // R6
  AST_RPT_ENDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mode_q.rpt) |-> (bc_o == '0)) else $error("repeat ended early"); // R5
  AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !wr_fire) |=> ($stable(hl_o) && $stable(de_o) && $stable(bc_o))) else $error("regs moved"); // R8
endmodule

// File: tb/blkx_engine_tb.sv
module blkx_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  mode_i;
  logic [15:0] hl_i, de_i, bc_i;
  logic        rd_valid_o, rd_ready_i, wr_valid_o, wr_ready_i;
  logic [15:0] rd_addr_o, wr_addr_o;
  logic [7:0]  rd_data_i, wr_data_o;
  logic        busy_o, done_o, flag_h_o, flag_n_o, flag_pv_o;
  logic [15:0] hl_o, de_o, bc_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_en = 1'b0;
  bit dir_dec = 1'b0;
  logic [15:0] exp_src, exp_dst;
  int wr_count = 0;
  int mism = 0;

  localparam int WATCHDOG = 195000;

  always #5 clk = ~clk;

  blkx_engine u_dut (.*);

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // Memory responder, acts away from the active edge.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (stall_en) begin
      rd_ready_i <= rd_valid_o && (cyc % 3 == 2);
      wr_ready_i <= wr_valid_o && (cyc % 4 == 1);
    end else begin
      rd_ready_i <= rd_valid_o;
      wr_ready_i <= wr_valid_o;
    end
    rd_data_i <= mem_byte(rd_addr_o);
    if (rd_valid_o && (!stall_en || cyc % 3 == 2)) begin
      if (rd_addr_o != exp_src) mism <= mism + 1;
    end
    if (wr_valid_o && (!stall_en || cyc % 4 == 1)) begin
      if (wr_addr_o != exp_dst || wr_data_o != mem_byte(exp_src)) mism <= mism + 1;
      wr_count <= wr_count + 1;
      exp_src  <= dir_dec ? exp_src - 16'd1 : exp_src + 16'd1;
      exp_dst  <= dir_dec ? exp_dst - 16'd1 : exp_dst + 16'd1;
    end
    if (cyc > WATCHDOG) begin
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
      errors = errors + 1;
      checks = checks + 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {mode, hl, de, bc, exp_hl, exp_de, exp_bc, exp_pv, exp_count}
  localparam int NV = 8;
  localparam logic [115:0] VEC [NV] = '{
    {2'b00, 16'h1000, 16'h2000, 16'h0005, 16'h1001, 16'h2001, 16'h0004, 1'b1, 17'd1},
    {2'b01, 16'h1000, 16'h2000, 16'h0001, 16'h0FFF, 16'h1FFF, 16'h0000, 1'b0, 17'd1},
    {2'b00, 16'hFFFF, 16'h0010, 16'h0000, 16'h0000, 16'h0011, 16'hFFFF, 1'b1, 17'd1},
    {2'b01, 16'h0000, 16'h0000, 16'h0003, 16'hFFFF, 16'hFFFF, 16'h0002, 1'b1, 17'd1},
    {2'b10, 16'h3000, 16'h4000, 16'h0004, 16'h3004, 16'h4004, 16'h0000, 1'b0, 17'd4},
    {2'b11, 16'h3000, 16'h4000, 16'h0003, 16'h2FFD, 16'h3FFD, 16'h0000, 1'b0, 17'd3},
    {2'b10, 16'hFFFE, 16'h0100, 16'h0004, 16'h0002, 16'h0104, 16'h0000, 1'b0, 17'd4},
    {2'b11, 16'h0001, 16'h8000, 16'h0002, 16'hFFFF, 16'h7FFE, 16'h0000, 1'b0, 17'd2}
  };

  task automatic run_vec(input logic [115:0] v, input bit stall, input bit poke_busy);
    stall_en = stall;
    dir_dec  = v[114];
    exp_src  = v[113:98];
    exp_dst  = v[97:82];
    wr_count = 0;
    mism     = 0;
    @(negedge clk);
    start_i = 1'b1; mode_i = v[115:114]; hl_i = v[113:98]; de_i = v[97:82]; bc_i = v[81:66];
    @(negedge clk);
    start_i = 1'b0;
    chk("R7 busy after start", {31'd0, busy_o}, 32'd1);
    if (poke_busy) begin
      @(negedge clk);
      start_i = 1'b1; mode_i = 2'b01; hl_i = 16'hAAAA; de_i = 16'h5555; bc_i = 16'h0009;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    chk("R3 hl", {16'd0, hl_o}, {16'd0, v[65:50]});
    chk("R3 de", {16'd0, de_o}, {16'd0, v[49:34]});
    chk("R5 bc", {16'd0, bc_o}, {16'd0, v[33:18]});
    chk("R6 pv", {31'd0, flag_pv_o}, {31'd0, v[17]});
    chk("R6 h n", {30'd0, flag_h_o, flag_n_o}, 32'd0);
    chk("R4 element count", wr_count, {15'd0, v[16:0]});
    chk("R2 addr/data sequence", mism, 32'd0);
    @(negedge clk);
    chk("R7 done one cycle", {30'd0, done_o, busy_o}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = '0; hl_i = '0; de_i = '0; bc_i = '0;
    rd_ready_i = 1'b0; wr_ready_i = 1'b0; rd_data_i = '0;
    exp_src = '0; exp_dst = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset ctl", {28'd0, busy_o, done_o, rd_valid_o, wr_valid_o}, 32'd0);
    chk("R9 reset regs", {bc_o, hl_o | de_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after release", {31'd0, busy_o}, 32'd0);

    // R1 vector walk, alternating memory stall patterns
    for (int i = 0; i < NV; i++) run_vec(VEC[i], i[0], 1'b0);

    // R8 start while busy is ignored
    run_vec({2'b10, 16'h0500, 16'h0600, 16'h0003, 16'h0503, 16'h0603, 16'h0000, 1'b0, 17'd3}, 1'b1, 1'b1);

    // R5 count of zero in repeat mode gives 65536 elements
    run_vec({2'b10, 16'h1234, 16'h8000, 16'h0000, 16'h1234, 16'h8000, 16'h0000, 1'b0, 17'd65536}, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule